// File: doc/BRIEF.md
# Serial Flash Sector-Erase Command Controller

This block is the device side of a serial-flash command port. It acts as a SPI mode 0 slave and is oversampled by the system clock. It understands three commands: one sets the write-enable latch, one streams out the status byte, and one erases a single 4KB sector. Inside the block, a status byte holds the write-in-progress flag, the write-enable latch and three block-protect bits. The protect bits come from a configuration input, because this block has no path that writes the status register.

An erase frame is checked before anything happens. The frame must be exactly 32 bits long, the latch must already be set, the block must be idle, and the target sector must lie outside the protected region. If all of this holds, the rising chip select that closes the frame starts a self-timed cycle. The length of that cycle, in system clocks, comes from an input. For the whole cycle the block holds an erase strobe high towards the memory array and presents the sector index with it. The host polls the status byte to learn when the cycle has ended.

Top module: `sector_erase_ctrl`

## Requirements
- R1: After reset, miso is 0, erase_stb is 0, and the status byte reads with WIP (bit 0) = 0 and WEL (bit 1) = 0.
- R2: A frame of exactly 8 bits carrying code 06h sets WEL (status bit 1) when chip select rises.
- R3: After the 8-bit code 05h, the status byte is shifted out on miso MSB first, one bit per falling sclk edge. The byte repeats for as long as chip select stays low. Layout: bit0 WIP, bit1 WEL, bits4:2 BP2..BP0 (taken from bp_cfg), bits7:5 zero.
- R4: An erase frame is the code 20h followed by a 24-bit address, MSB first. A frame that is not exactly 32 bits long when chip select rises starts nothing and leaves WEL unchanged.
- R5: An erase frame received while WEL = 0 is ignored.
- R6: A valid erase raises erase_stb after chip select rises. erase_stb stays high for erase_len system clocks (an erase_len of 0 counts as 1). erase_sector holds address bits 20:12 for that whole time, and address bits 23:21 have no effect.
- R7: WIP reads 1 for the whole erase cycle and 0 afterwards. WEL clears when the cycle starts.
- R8: When bp_cfg is nonzero, sectors at or above 512 - (512 >> (7 - bp_cfg)) are protected. An erase aimed at a protected sector is not executed and WEL stays 1.
- R9: While WIP = 1, every command except the status read is ignored. In particular, 06h does not set WEL.
- R10: A frame with any other command code changes neither the status byte nor erase_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host (mode 0) |
| cs_n | input | 1 | Active-low chip select that frames each command |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial status data to the host |
| bp_cfg | input | 3 | Block-protect level, reflected in status bits 4:2 |
| erase_len | input | 16 | Erase cycle length in system clocks |
| erase_stb | output | 1 | High throughout an erase cycle |
| erase_sector | output | 9 | 4KB sector index being erased |

## Verification
A latch that sets or clears at the wrong moment shows up in the next status read: bit 1 is wrong there, within one frame of the fault. An erase that starts wrongly appears on erase_stb a few clocks after chip select rises. An erase that is wrongly refused is caught at the end of the run, when the expected strobe never arrived. A wrong cycle counter or sector register is seen when the strobe falls or rises, because the measured strobe length or the sector index does not match the expected value. A status read placed inside the erase window checks WIP and the cleared latch while the cycle is still running.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    localparam int FRAME_BITS  = 32;
    localparam int SECTOR_LSB  = 12;
    localparam int SECTOR_W    = 9;
    localparam int LEN_W       = 16;

    localparam logic [7:0] OP_SET_LATCH = 8'h06;
    localparam logic [7:0] OP_READ_STAT = 8'h05;
    localparam logic [7:0] OP_ERASE_4K  = 8'h20;

    typedef struct packed {
        logic [2:0] zero;
        logic [2:0] bp;
        logic       wel;
        logic       wip;
    } status_t;

    // Protected when the sector lies in the top 1/2^(7-bp) of the array
    function automatic logic sector_locked(input logic [SECTOR_W-1:0] s,
                                           input logic [2:0] bp);
        logic [SECTOR_W:0] whole;
        logic [SECTOR_W:0] span;
        logic [SECTOR_W:0] first;
        whole = {1'b1, {SECTOR_W{1'b0}}};
        span  = whole >> (3'd7 - bp);
        first = whole - span;
        if (bp == 3'd0) return 1'b0;
        return {1'b0, s} >= first;
    endfunction

endpackage

// File: rtl/spi_slave_frontend.sv
module spi_slave_frontend
    import flash_erase_pkg::*;
#(
    parameter int FRAME_W = FRAME_BITS,
    parameter int SECT_LSB = SECTOR_LSB,
    parameter int SECT_W = SECTOR_W,
    localparam int CNT_W = $clog2(FRAME_W + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               mosi,
    input  status_t            status,
    output logic               miso,
    output logic               frame_end,
    output logic [CNT_W-1:0]   bits,
    output logic [7:0]         head_op,
    output logic [7:0]         last_op,
    output logic [SECT_W-1:0]  frame_sector
);
    localparam logic [CNT_W-1:0] BITS_SAT = CNT_W'(FRAME_W + 1);
    localparam logic [CNT_W-1:0] OP_BITS  = CNT_W'(8);

    logic [2:0] sclk_s;
    logic [2:0] cs_s;
    logic [1:0] mosi_s;
    logic [FRAME_W-1:0] word;
    logic [7:0] opc;
    logic [7:0] tx_reg;
    logic [2:0] tx_idx;
    logic sclk_rise, sclk_fall, sel, rd_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_s <= '0;
            cs_s   <= '1;
            mosi_s <= '0;
        end else begin
            sclk_s <= {sclk_s[1:0], sclk};
            cs_s   <= {cs_s[1:0], cs_n};
            mosi_s <= {mosi_s[0], mosi};
        end
    end

    assign sclk_rise = sclk_s[1] & ~sclk_s[2];
    assign sclk_fall = ~sclk_s[1] & sclk_s[2];
    assign sel       = ~cs_s[1];
    assign frame_end = cs_s[1] & ~cs_s[2];
    assign rd_on     = sel && (opc == OP_READ_STAT) && (bits >= OP_BITS);

    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            bits <= '0;
            word <= '0;
            opc  <= '0;
        end else if (sclk_rise) begin
            word <= {word[FRAME_W-2:0], mosi_s[1]};
            if (bits != BITS_SAT) bits <= bits + 1'b1;
            if (bits == OP_BITS - 1'b1) opc <= {word[6:0], mosi_s[1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            tx_reg <= '0;
            tx_idx <= '0;
        end else if (sclk_fall && rd_on) begin
            tx_reg <= (tx_idx == 3'd0) ? status : {tx_reg[6:0], 1'b0};
            tx_idx <= tx_idx + 1'b1;
        end
    end

    assign miso         = tx_reg[7];
    assign head_op      = word[FRAME_W-1 -: 8];
    assign last_op      = word[7:0];
    assign frame_sector = word[SECT_LSB + SECT_W - 1 : SECT_LSB];
endmodule

// File: rtl/erase_cmd_decode.sv
module erase_cmd_decode
    import flash_erase_pkg::*;
#(
    parameter int FRAME_W = FRAME_BITS,
    parameter int SECT_W = SECTOR_W,
    localparam int CNT_W = $clog2(FRAME_W + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_end,
    input  logic [CNT_W-1:0]  bits,
    input  logic [7:0]        head_op,
    input  logic [7:0]        last_op,
    input  logic [SECT_W-1:0] frame_sector,
    input  logic              busy,
    input  logic [2:0]        bp,
    output logic              wel,
    output logic              start,
    output logic [SECT_W-1:0] sector
);
    logic latch_hit, erase_hit;

    assign latch_hit = frame_end && !busy && (bits == CNT_W'(8))
                       && (last_op == OP_SET_LATCH);
    assign erase_hit = frame_end && !busy && wel && (bits == CNT_W'(FRAME_W))
                       && (head_op == OP_ERASE_4K)
                       && !sector_locked(frame_sector, bp);

    always_ff @(posedge clk) begin
        if (rst) begin
            wel    <= 1'b0;
            start  <= 1'b0;
            sector <= '0;
        end else begin
            start <= erase_hit;
            if (erase_hit) begin
                sector <= frame_sector;
                wel    <= 1'b0;
            end else if (latch_hit) begin
                wel <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/erase_cycle_timer.sv
module erase_cycle_timer #(
    parameter int LEN_BITS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [LEN_BITS-1:0] len,
    output logic                busy
);
    logic [LEN_BITS-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= (len == '0) ? LEN_BITS'(1) : len;
        end else if (busy) begin
            remain <= remain - 1'b1;
            if (remain == LEN_BITS'(1)) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/sector_erase_ctrl.sv
module sector_erase_ctrl
    import flash_erase_pkg::*;
#(
    parameter int FRAME_W = FRAME_BITS,
    parameter int SECT_LSB = SECTOR_LSB,
    parameter int SECT_W = SECTOR_W,
    parameter int LEN_BITS = LEN_W,
    localparam int CNT_W = $clog2(FRAME_W + 2)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sclk,
    input  logic                cs_n,
    input  logic                mosi,
    output logic                miso,
    input  logic [2:0]          bp_cfg,
    input  logic [LEN_BITS-1:0] erase_len,
    output logic                erase_stb,
    output logic [SECT_W-1:0]   erase_sector
);
    status_t           status;
    logic              frame_end;
    logic [CNT_W-1:0]  bits;
    logic [7:0]        head_op, last_op;
    logic [SECT_W-1:0] frame_sector;
    logic              wel_q, start_q, busy;

    assign status = '{zero: 3'b000, bp: bp_cfg, wel: wel_q, wip: busy};

    spi_slave_frontend #(.FRAME_W(FRAME_W), .SECT_LSB(SECT_LSB), .SECT_W(SECT_W)) u_fe (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .status(status), .miso(miso), .frame_end(frame_end), .bits(bits),
        .head_op(head_op), .last_op(last_op), .frame_sector(frame_sector)
    );

    erase_cmd_decode #(.FRAME_W(FRAME_W), .SECT_W(SECT_W)) u_dec (
        .clk(clk), .rst(rst), .frame_end(frame_end), .bits(bits),
        .head_op(head_op), .last_op(last_op), .frame_sector(frame_sector),
        .busy(busy), .bp(bp_cfg), .wel(wel_q), .start(start_q),
        .sector(erase_sector)
    );

    erase_cycle_timer #(.LEN_BITS(LEN_BITS)) u_tmr (
        .clk(clk), .rst(rst), .start(start_q), .len(erase_len), .busy(busy)
    );

    assign erase_stb = busy;
endmodule

// File: rtl/sector_erase_chk.sv
module sector_erase_chk
    import flash_erase_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                frame_end,
    input logic                start,
    input logic                busy,
    input logic                wel,
    input logic [2:0]          bp,
    input logic [SECTOR_W-1:0] sector
);
    p_wel_set_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> $past(frame_end));

    p_start_wel_r5: assert property (@(posedge clk) disable iff (rst)
        start |-> $past(wel));

    p_sector_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(sector));

    p_wel_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !wel);

    p_unlocked_r8: assert property (@(posedge clk) disable iff (rst)
        start |-> !sector_locked(sector, $past(bp)));

    p_idle_start_r9: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
endmodule

bind sector_erase_ctrl sector_erase_chk u_chk (
    .clk(clk), .rst(rst), .frame_end(frame_end), .start(start_q),
    .busy(busy), .wel(wel_q), .bp(bp_cfg), .sector(erase_sector)
);

// File: tb/sector_erase_ctrl_test.sv
module sector_erase_ctrl_test;
    localparam int HALF = 8;

    typedef struct {
        int sector;
        int len;
    } exp_erase_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [2:0]  bp_cfg = 3'd0;
    logic [15:0] erase_len = 16'd1500;
    logic        erase_stb;
    logic [8:0]  erase_sector;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    exp_erase_t exp_q[$];

    always #2.5 clk = ~clk;

    sector_erase_ctrl uut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .bp_cfg(bp_cfg), .erase_len(erase_len),
        .erase_stb(erase_stb), .erase_sector(erase_sector)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: pops one expected erase per strobe and checks it
    exp_erase_t cur;
    bit prev_stb = 1'b0;
    int run = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (erase_stb && !prev_stb) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected erase strobe", erase_sector, 0);
                    cur = '{sector: -1, len: -1};
                end else begin
                    cur = exp_q.pop_front();
                    chk(erase_sector == 9'(cur.sector), "R6", "erase sector",
                        erase_sector, cur.sector);
                end
                run = 0;
            end
            if (erase_stb) run++;
            if (!erase_stb && prev_stb && cur.len >= 0)
                chk(run == cur.len, "R6", "strobe length", run, cur.len);
            prev_stb = erase_stb;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic desel();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(4 * HALF);
    endtask

    task automatic shift(input logic [31:0] v, input int n, inout logic [31:0] got);
        for (int i = n - 1; i >= 0; i--) begin
            mosi = v[i];
            wait_clk(HALF);
            got = {got[30:0], miso};
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic send_cmd(input logic [7:0] op);
        logic [31:0] g = '0;
        sel();
        shift({24'd0, op}, 8, g);
        desel();
    endtask

    task automatic send_erase(input logic [23:0] addr, input int n);
        logic [31:0] g = '0;
        logic [31:0] frame = {8'h20, addr};
        sel();
        if (n <= 32) begin
            shift(frame >> (32 - n), n, g);
        end else begin
            shift(frame, 32, g);
            shift(32'd0, n - 32, g);
        end
        desel();
    endtask

    task automatic read_status(input logic [7:0] exp, input int nbytes, input string req);
        logic [31:0] g = '0;
        sel();
        shift(32'h05, 8, g);
        for (int b = 0; b < nbytes; b++) begin
            shift(32'd0, 8, g);
            chk(g[7:0] == exp, req, "status byte", g[7:0], exp);
        end
        desel();
    endtask

    task automatic wait_erase_done();
        wait_clk(8);
        while (erase_stb) @(negedge clk);
        wait_clk(8);
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        // R1: reset state
        chk(miso == 1'b0, "R1", "miso after reset", miso, 0);
        chk(erase_stb == 1'b0, "R1", "erase_stb after reset", erase_stb, 0);
        read_status(8'h00, 1, "R1");

        // R5: erase without latch
        send_erase(24'h123456, 32);
        wait_clk(20);
        chk(erase_stb == 1'b0, "R5", "erase without latch", erase_stb, 0);
        read_status(8'h00, 1, "R5");

        // R10: unknown code
        send_cmd(8'h9F);
        read_status(8'h00, 1, "R10");

        // R2 / R3: latch set, status repeated in one frame
        send_cmd(8'h06);
        read_status(8'h02, 3, "R3");
        send_cmd(8'hAB);
        read_status(8'h02, 1, "R10");

        // R4: short and long erase frames
        send_erase(24'h123456, 31);
        read_status(8'h02, 1, "R4");
        send_erase(24'h123456, 33);
        wait_clk(20);
        chk(erase_stb == 1'b0, "R4", "overlong frame strobe", erase_stb, 0);
        read_status(8'h02, 1, "R4");

        // R6 / R7 / R9: valid erase, poll during, ignored latch command
        exp_q.push_back('{sector: 'h123, len: 1500});
        send_erase(24'h123456, 32);
        read_status(8'h01, 1, "R7");
        send_cmd(8'h06);
        read_status(8'h01, 1, "R9");
        chk(erase_stb == 1'b1, "R7", "strobe still high", erase_stb, 1);
        wait_erase_done();
        read_status(8'h00, 1, "R9");

        // R6: address bits 23:21 ignored, short cycle
        erase_len = 16'd20;
        send_cmd(8'h06);
        exp_q.push_back('{sector: 'h001, len: 20});
        send_erase(24'hE01ABC, 32);
        wait_erase_done();
        read_status(8'h00, 1, "R6");

        // R6: zero length counts as one clock
        erase_len = 16'd0;
        send_cmd(8'h06);
        exp_q.push_back('{sector: 'h0AA, len: 1});
        send_erase(24'h0AA000, 32);
        wait_erase_done();
        erase_len = 16'd20;

        // R8: protection levels
        bp_cfg = 3'd1;
        send_cmd(8'h06);
        read_status(8'h06, 1, "R8");
        send_erase(24'h1FE000, 32);
        wait_clk(20);
        chk(erase_stb == 1'b0, "R8", "protected sector 510", erase_stb, 0);
        read_status(8'h06, 1, "R8");
        exp_q.push_back('{sector: 503, len: 20});
        send_erase(24'h1F7000, 32);
        wait_erase_done();
        read_status(8'h04, 1, "R8");

        bp_cfg = 3'd7;
        send_cmd(8'h06);
        send_erase(24'h000000, 32);
        read_status(8'h1E, 1, "R8");

        bp_cfg = 3'd6;
        send_erase(24'h100000, 32);
        read_status(8'h1A, 1, "R8");
        exp_q.push_back('{sector: 255, len: 20});
        send_erase(24'h0FF000, 32);
        wait_erase_done();
        read_status(8'h18, 1, "R8");

        wait_clk(50);
        chk(exp_q.size() == 0, "R6", "expected erases outstanding", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule